// File: doc/BRIEF.md
# Opcode Decoder and Fetch Sequencer

This block sits at the front of a small 8-bit processor's instruction path. It accepts instruction bytes one at a time on a valid-qualified byte input. The first byte of each instruction is the opcode. The block sorts the opcode into a class and works out whether zero, one or two more bytes follow. It then gathers those bytes and presents the decoded fields on registered outputs. The fields are the class code, destination and source register numbers, the ALU sub-operation, the branch condition, the I/O port number, the immediate byte and a 14-bit target address.

A one-cycle `instrDone` strobe marks the cycle in which every field of the instruction is valid. During that cycle the block drops any byte offered to it. The next valid byte after the strobe is taken as a fresh opcode. Halt encodings and unimplemented encodings are flagged. Both are sequenced as one-byte instructions. Any field that a class does not use reads zero. Executing the instruction, reaching memory and holding the register file are the job of other blocks.

Top module: `opcode_fetch_decoder`

## Requirements
- R1: After reset, `instrDone`, `haltFlag` and `illegalFlag` are 0, `opClass` is 0 (none), and every field output is 0.
- R2: For a one-byte opcode, `instrDone` is 1 for exactly the one cycle after the opcode is accepted. A byte offered during that cycle is dropped and changes no output.
- R3: Opcodes 00xxx100 (ALU with immediate, class 2) and 00ddd110 (load immediate, class 4) take the next valid byte into `immValue`. `instrDone` follows one cycle later. For class 4, `dstReg` is bits 5..3.
- R4: Opcodes 01xxx0x0 and 01xxx1x0 are followed by a low address byte and then a high address byte. `jumpAddr` is {high[5:0], low}, and high bits 7..6 are dropped. Bit 1 selects call (class 8) over jump (class 7).
- R5: Opcodes 10ooosss are class 1 with `aluOp` = bits 5..3 and `srcReg` = bits 2..0. Class 2 also reports `aluOp` = bits 5..3.
- R6: Opcodes 11dddsss other than 0xFF are class 3 with `dstReg` = bits 5..3 and `srcReg` = bits 2..0.
- R7: Opcodes 0x00, 0x01 and 0xFF are class 13 and raise `haltFlag`. Each takes one byte.
- R8: Opcodes 0x38, 0x39, 0x22, 0x2A, 0x32 and 0x3A are class 14. They raise `illegalFlag` and take one byte, with all fields zero.
- R9: Opcodes 01xxxxx1 report `ioPort` = bits 5..1. They are class 11 (input) when that port is below 8, and class 12 (output) otherwise. Each takes one byte.
- R10: Jumps and calls with bits 2..1 = 00 or 01, and returns of form 00ccc011, set `condUsed` = 1 and `condCode` = bits 5..3. Jumps and calls with bit 2 = 1, and returns of form 00xxx111, set `condUsed` = 0. Returns are class 9 and take one byte.
- R11: Opcodes 00aaa101 are class 10 (restart). They take one byte, and `jumpAddr` = aaa × 8.
- R12: Opcodes 00ddd00x with ddd in 1..6 are class 5, with `dstReg` = ddd and `aluOp` = bit 0 (0 increment, 1 decrement). Opcodes 000oo010 are class 6 (rotate), with `aluOp` = {0, oo}.
- R13: Cycles with `byteValid` low do not advance the sequence. `instrDone` stays 0 while operand bytes are still awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | `byteIn` carries a byte this cycle |
| byteIn | input | 8 | Instruction byte |
| instrDone | output | 1 | One-cycle strobe: all fields valid |
| opClass | output | 4 | Instruction class code |
| condUsed | output | 1 | Branch or return is conditional |
| condCode | output | 3 | Condition selector |
| aluOp | output | 3 | ALU, inc/dec or rotate sub-operation |
| dstReg | output | 3 | Destination register number |
| srcReg | output | 3 | Source register number |
| ioPort | output | 5 | I/O port number |
| immValue | output | 8 | Immediate operand |
| jumpAddr | output | ADDR_W | Target address or restart vector |
| haltFlag | output | 1 | Current instruction is a halt |
| illegalFlag | output | 1 | Current instruction is unimplemented |

## Verification
The bench sweeps all 256 opcodes, each with distinct operand bytes, and compares every output against a model built from the requirements. The special encodings get the most attention. A decoder that treated 0xFF as a move, 0x00/0x01 as increment/decrement, or 0x38/0x39 as valid would report the wrong class, and for 0xFF it would also report register fields. The bench feeds high address bytes with bits 7..6 set, so leakage of those bits into `jumpAddr` shows up. It offers a stray opcode in every done slot, so a sequencer that accepts it would strobe `instrDone` a second time or change the class. Idle gaps between operand bytes catch a sequencer that advances without `byteValid`.

// File: rtl/op_seq_pkg.sv
package op_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 3;
  localparam int PORT_W = 5;

  typedef enum logic [3:0] {
    CLS_NONE     = 4'd0,
    CLS_ALU_REG  = 4'd1,
    CLS_ALU_IMM  = 4'd2,
    CLS_MOVE     = 4'd3,
    CLS_LOAD_IMM = 4'd4,
    CLS_INCDEC   = 4'd5,
    CLS_ROTATE   = 4'd6,
    CLS_JUMP     = 4'd7,
    CLS_CALL     = 4'd8,
    CLS_RETURN   = 4'd9,
    CLS_RESTART  = 4'd10,
    CLS_INPUT    = 4'd11,
    CLS_OUTPUT   = 4'd12,
    CLS_HALT     = 4'd13,
    CLS_ILLEGAL  = 4'd14
  } opClass_e;

  typedef struct packed {
    opClass_e           cls;
    logic               condUsed;
    logic [REG_W-1:0]   condCode;
    logic [REG_W-1:0]   aluOp;
    logic [REG_W-1:0]   dstReg;
    logic [REG_W-1:0]   srcReg;
    logic [PORT_W-1:0]  ioPort;
    logic [REG_W-1:0]   rstSlot;
  } decodeInfo_t;

  typedef struct packed {
    logic takeOpcode;
    logic takeImm;
    logic takeLo;
    logic takeHi;
  } seqStrobe_t;
endpackage

// File: rtl/op_classify.sv
module op_classify
  import op_seq_pkg::*;
(
  input  logic [BYTE_W-1:0] byteIn,
  output decodeInfo_t       info,
  output logic [1:0]        opLen
);
  logic [1:0] top;
  logic [2:0] mid;
  logic [2:0] low;

  assign top = byteIn[7:6];
  assign mid = byteIn[5:3];
  assign low = byteIn[2:0];

  always_comb begin
    info  = '0;
    opLen = 2'd1;
    unique case (top)
      2'b10: begin
        info.cls    = CLS_ALU_REG;
        info.aluOp  = mid;
        info.srcReg = low;
      end
      2'b11: begin
        if (byteIn == 8'hFF) begin
          info.cls = CLS_HALT;
        end else begin
          info.cls    = CLS_MOVE;
          info.dstReg = mid;
          info.srcReg = low;
        end
      end
      2'b01: begin
        if (byteIn[0]) begin
          info.ioPort = byteIn[5:1];
          info.cls    = (byteIn[5:4] == 2'b00) ? CLS_INPUT : CLS_OUTPUT;
        end else begin
          opLen         = 2'd3;
          info.cls      = byteIn[1] ? CLS_CALL : CLS_JUMP;
          info.condUsed = ~byteIn[2];
          info.condCode = byteIn[2] ? 3'd0 : mid;
        end
      end
      default: begin
        unique case (low)
          3'd0, 3'd1: begin
            if (mid == 3'd0) begin
              info.cls = CLS_HALT;
            end else if (mid == 3'd7) begin
              info.cls = CLS_ILLEGAL;
            end else begin
              info.cls    = CLS_INCDEC;
              info.dstReg = mid;
              info.aluOp  = {2'b00, byteIn[0]};
            end
          end
          3'd2: begin
            if (mid[2]) begin
              info.cls = CLS_ILLEGAL;
            end else begin
              info.cls   = CLS_ROTATE;
              info.aluOp = {1'b0, mid[1:0]};
            end
          end
          3'd3: begin
            info.cls      = CLS_RETURN;
            info.condUsed = 1'b1;
            info.condCode = mid;
          end
          3'd4: begin
            info.cls   = CLS_ALU_IMM;
            info.aluOp = mid;
            opLen      = 2'd2;
          end
          3'd5: begin
            info.cls     = CLS_RESTART;
            info.rstSlot = mid;
          end
          3'd6: begin
            info.cls    = CLS_LOAD_IMM;
            info.dstReg = mid;
            opLen       = 2'd2;
          end
          default: info.cls = CLS_RETURN;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/op_seq_ctrl.sv
module op_seq_ctrl
  import op_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [1:0] opLen,
  output seqStrobe_t strobe,
  output logic       instrDone
);
  typedef enum logic [2:0] {
    ST_OPCODE, ST_IMM, ST_ADDR_LO, ST_ADDR_HI, ST_DONE
  } seqState_e;

  seqState_e stateQ;
  seqState_e stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_OPCODE: begin
        strobe.takeOpcode = byteValid;
        if (byteValid) begin
          unique case (opLen)
            2'd2:    stateNext = ST_IMM;
            2'd3:    stateNext = ST_ADDR_LO;
            default: stateNext = ST_DONE;
          endcase
        end
      end
      ST_IMM: begin
        strobe.takeImm = byteValid;
        if (byteValid) stateNext = ST_DONE;
      end
      ST_ADDR_LO: begin
        strobe.takeLo = byteValid;
        if (byteValid) stateNext = ST_ADDR_HI;
      end
      ST_ADDR_HI: begin
        strobe.takeHi = byteValid;
        if (byteValid) stateNext = ST_DONE;
      end
      default: stateNext = ST_OPCODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_OPCODE;
    else       stateQ <= stateNext;
  end

  assign instrDone = (stateQ == ST_DONE);
endmodule

// File: rtl/op_seq_datapath.sv
module op_seq_datapath
  import op_seq_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [BYTE_W-1:0]  byteIn,
  input  decodeInfo_t        info,
  output opClass_e           opClass,
  output logic               condUsed,
  output logic [REG_W-1:0]   condCode,
  output logic [REG_W-1:0]   aluOp,
  output logic [REG_W-1:0]   dstReg,
  output logic [REG_W-1:0]   srcReg,
  output logic [PORT_W-1:0]  ioPort,
  output logic [BYTE_W-1:0]  immValue,
  output logic [ADDR_W-1:0]  jumpAddr,
  output logic               haltFlag,
  output logic               illegalFlag
);
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam int SLOT_W = REG_W + 3;

  logic [ADDR_W-1:0] restartVec;
  assign restartVec = ADDR_W'({info.rstSlot, 3'b000});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opClass  <= CLS_NONE;
      condUsed <= 1'b0;
      condCode <= '0;
      aluOp    <= '0;
      dstReg   <= '0;
      srcReg   <= '0;
      ioPort   <= '0;
      immValue <= '0;
      jumpAddr <= '0;
    end else begin
      if (strobe.takeOpcode) begin
        opClass  <= info.cls;
        condUsed <= info.condUsed;
        condCode <= info.condCode;
        aluOp    <= info.aluOp;
        dstReg   <= info.dstReg;
        srcReg   <= info.srcReg;
        ioPort   <= info.ioPort;
        immValue <= '0;
        jumpAddr <= (info.cls == CLS_RESTART) ? restartVec : '0;
      end
      if (strobe.takeImm) immValue <= byteIn;
      if (strobe.takeLo)  jumpAddr[BYTE_W-1:0] <= byteIn;
      if (strobe.takeHi)  jumpAddr[ADDR_W-1:BYTE_W] <= byteIn[HI_W-1:0];
    end
  end

  assign haltFlag    = (opClass == CLS_HALT);
  assign illegalFlag = (opClass == CLS_ILLEGAL);

  if (SLOT_W > ADDR_W) begin : g_bad_width
    initial $display("op_seq_datapath: ADDR_W too small for restart vector");
  end
endmodule

// File: rtl/opcode_fetch_decoder.sv
module opcode_fetch_decoder
  import op_seq_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  output logic              instrDone,
  output logic [3:0]        opClass,
  output logic              condUsed,
  output logic [2:0]        condCode,
  output logic [2:0]        aluOp,
  output logic [2:0]        dstReg,
  output logic [2:0]        srcReg,
  output logic [4:0]        ioPort,
  output logic [7:0]        immValue,
  output logic [ADDR_W-1:0] jumpAddr,
  output logic              haltFlag,
  output logic              illegalFlag
);
  decodeInfo_t info;
  logic [1:0]  opLen;
  seqStrobe_t  strobe;
  opClass_e    classQ;
  logic        acceptOpcode;

  op_classify i_classify (
    .byteIn (byteIn),
    .info   (info),
    .opLen  (opLen)
  );

  op_seq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .opLen     (opLen),
    .strobe    (strobe),
    .instrDone (instrDone)
  );

  op_seq_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .byteIn      (byteIn),
    .info        (info),
    .opClass     (classQ),
    .condUsed    (condUsed),
    .condCode    (condCode),
    .aluOp       (aluOp),
    .dstReg      (dstReg),
    .srcReg      (srcReg),
    .ioPort      (ioPort),
    .immValue    (immValue),
    .jumpAddr    (jumpAddr),
    .haltFlag    (haltFlag),
    .illegalFlag (illegalFlag)
  );

  assign opClass      = classQ;
  assign acceptOpcode = strobe.takeOpcode;
endmodule

// File: rtl/op_fetch_checker.sv
module op_fetch_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        byteIn,
  input logic              acceptOpcode,
  input logic              instrDone,
  input logic [3:0]        opClass,
  input logic [2:0]        aluOp,
  input logic [4:0]        ioPort,
  input logic [7:0]        immValue,
  input logic [ADDR_W-1:0] jumpAddr,
  input logic              haltFlag,
  input logic              illegalFlag
);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |=> !instrDone);

  p_done_slot_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |=> ($stable(opClass) && $stable(immValue) && $stable(jumpAddr)));

  p_halt_codes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOpcode && (byteIn == 8'h00 || byteIn == 8'h01 || byteIn == 8'hFF))
      |=> (haltFlag && instrDone));

  p_unimpl_nop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOpcode && (byteIn == 8'h38 || byteIn == 8'h39))
      |=> (illegalFlag && instrDone));

  p_alu_field_r5: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOpcode && byteIn[7:6] == 2'b10) |=> (instrDone && aluOp == $past(byteIn[5:3])));

  p_io_port_r9: assert property (@(posedge clk) disable iff (!rstN)
    (acceptOpcode && byteIn[7:6] == 2'b01 && byteIn[0]) |=> (instrDone && ioPort == $past(byteIn[5:1])));
endmodule

bind opcode_fetch_decoder op_fetch_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .byteIn       (byteIn),
  .acceptOpcode (acceptOpcode),
  .instrDone    (instrDone),
  .opClass      (opClass),
  .aluOp        (aluOp),
  .ioPort       (ioPort),
  .immValue     (immValue),
  .jumpAddr     (jumpAddr),
  .haltFlag     (haltFlag),
  .illegalFlag  (illegalFlag)
);

// File: tb/test_opcode_fetch_decoder.sv
module test_opcode_fetch_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = 8'h00;
  logic        instrDone;
  logic [3:0]  opClass;
  logic        condUsed;
  logic [2:0]  condCode, aluOp, dstReg, srcReg;
  logic [4:0]  ioPort;
  logic [7:0]  immValue;
  logic [13:0] jumpAddr;
  logic        haltFlag, illegalFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  opcode_fetch_decoder i_opcode_fetch_decoder (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .instrDone(instrDone), .opClass(opClass), .condUsed(condUsed),
    .condCode(condCode), .aluOp(aluOp), .dstReg(dstReg), .srcReg(srcReg),
    .ioPort(ioPort), .immValue(immValue), .jumpAddr(jumpAddr),
    .haltFlag(haltFlag), .illegalFlag(illegalFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    byteValid = 1'b1;
    byteIn    = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  // Expected model, built from the requirement list
  int eCls, eLen, eAlu, eDst, eSrc, eCondU, eCond, ePort, eJmpBase;
  task automatic model(input int op);
    int hi2, m, lo;
    hi2 = op / 64; m = (op / 8) % 8; lo = op % 8;
    eCls = 0; eLen = 1; eAlu = 0; eDst = 0; eSrc = 0;
    eCondU = 0; eCond = 0; ePort = 0; eJmpBase = 0;
    if (op == 0 || op == 1 || op == 255) eCls = 13;          // R7
    else if (hi2 == 2) begin eCls = 1; eAlu = m; eSrc = lo; end // R5
    else if (hi2 == 3) begin eCls = 3; eDst = m; eSrc = lo; end // R6
    else if (hi2 == 1) begin
      if (op % 2 == 1) begin                                   // R9
        ePort = (op / 2) % 32;
        eCls = (ePort < 8) ? 11 : 12;
      end else begin                                           // R4, R10
        eLen = 3;
        eCls = ((op / 2) % 2 == 1) ? 8 : 7;
        if ((op / 4) % 2 == 0) begin eCondU = 1; eCond = m; end
      end
    end else begin
      case (lo)
        0, 1: if (m == 7) eCls = 14;                           // R8
              else begin eCls = 5; eDst = m; eAlu = op % 2; end // R12
        2: if (m >= 4) eCls = 14; else begin eCls = 6; eAlu = m; end
        3: begin eCls = 9; eCondU = 1; eCond = m; end          // R10
        4: begin eCls = 2; eAlu = m; eLen = 2; end             // R3
        5: begin eCls = 10; eJmpBase = m * 8; end              // R11
        6: begin eCls = 4; eDst = m; eLen = 2; end             // R3
        default: eCls = 9;
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", int'(instrDone), 0);
    chk("R1 class", int'(opClass), 0);
    chk("R1 halt", int'(haltFlag), 0);
    chk("R1 illegal", int'(illegalFlag), 0);
    chk("R1 jump", int'(jumpAddr), 0);
    chk("R1 imm", int'(immValue), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle", int'(instrDone), 0);

    for (int op = 0; op < 256; op++) begin
      logic [7:0] immB, loB, hiB, stray;
      int expImm, expJmp;
      immB = 8'(op) ^ 8'hA5;
      loB  = 8'(op) + 8'h11;
      hiB  = ~8'(op) | 8'hC0;
      model(op);
      expImm = 0;
      expJmp = eJmpBase;
      pushByte(8'(op));
      if (eLen > 1) begin
        chk("R13 early done", int'(instrDone), 0);
        if (op % 3 == 0) begin
          repeat (2) @(negedge clk);
          chk("R13 gap", int'(instrDone), 0);
        end
        if (eLen == 2) begin
          pushByte(immB);
          expImm = int'(immB);
        end else begin
          pushByte(loB);
          chk("R4 mid", int'(instrDone), 0);
          pushByte(hiB);
          expJmp = int'(hiB[5:0]) * 256 + int'(loB);
        end
      end
      chk("R2 done", int'(instrDone), 1);
      chk("R5 class", int'(opClass), eCls);
      chk("R5 aluOp", int'(aluOp), eAlu);
      chk("R6 dstReg", int'(dstReg), eDst);
      chk("R6 srcReg", int'(srcReg), eSrc);
      chk("R10 condUsed", int'(condUsed), eCondU);
      chk("R10 condCode", int'(condCode), eCond);
      chk("R9 ioPort", int'(ioPort), ePort);
      chk("R3 immValue", int'(immValue), expImm);
      chk("R4 R11 jumpAddr", int'(jumpAddr), expJmp);
      chk("R7 haltFlag", int'(haltFlag), (eCls == 13) ? 1 : 0);
      chk("R8 illegalFlag", int'(illegalFlag), (eCls == 14) ? 1 : 0);
      // R2: a byte in the done slot is dropped
      stray = (eCls == 14) ? 8'h00 : 8'h38;
      pushByte(stray);
      chk("R2 stray done", int'(instrDone), 0);
      chk("R2 stray class", int'(opClass), eCls);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule